// File: doc/BRIEF.md
# Low-Power Entry Wakeup Guard

This block sits between a set of external wakeup lines and the power-management controller. As the system starts to enter a low-power state, software issues a one-cycle entry pulse. The pulse opens a keep-out window of fixed real-time length. While the window is open, no wakeup line reaches the controller. Any request seen during the window is captured per line in a sticky latch. When the window closes, the latch presents the request to the controller, so the request is not lost.

The window length is given in nanoseconds and converted to clock cycles from the clock-frequency parameter. The window therefore keeps the same real-time span when the clock changes. Outside the window, wakeup lines pass straight through without delay. A captured line stays asserted until the controller pulses the matching acknowledge bit.

Top module: `wkg_wakeup_guard`

## Requirements
- R1: While `rst_n` is low on a rising edge, the window is cleared and every latch is cleared. `wake_out` is all zero for as long as `rst_n` is low.
- R2: When `enter_lp` is sampled high on a rising edge, `window_active` is high for exactly HOLD = ceil(KEEPOUT_NS × CLK_HZ / 10^9) cycles after that edge. HOLD is 1500 at the defaults (6000 ns, 250 MHz). At all other times `window_active` is low.
- R3: `wake_out` is all zero in every cycle where `window_active` is high.
- R4: A `wake_in` bit that is high on a rising edge while the block is holding requests back sets that line's latch. Once the window has closed, the line shows high on `wake_out`.
- R5: A latched line stays high until its `wake_ack` bit is sampled high on a rising edge, and it is low from the next cycle. If a capture and an acknowledge for the same line fall on the same edge, the capture wins.
- R6: While the window is inactive and `enter_lp` is low, each `wake_out` bit equals its `wake_in` bit OR its latch in the same cycle, with no register delay.
- R7: An `enter_lp` pulse that arrives while the window is open restarts the full HOLD count from that edge.
- R8: Each line has its own latch. Acknowledging one bit leaves the other latched lines asserted.
- R9: A request that is high in the same cycle as `enter_lp` is not forwarded in that cycle. It is captured as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| enter_lp | input | 1 | One-cycle pulse issued by software as low-power entry begins |
| wake_in | input | LINES | Wakeup requests, synchronous to `clk` |
| wake_ack | input | LINES | Per-line acknowledge that clears a latched request |
| wake_out | output | LINES | Wakeup requests forwarded to the power controller |
| window_active | output | 1 | High while the keep-out window is open |

## Verification
The embedded properties check the following on every cycle:
- The gated outputs stay silent while the window or the entry pulse is present.
- An entry pulse opens the window on the following cycle.
- A closed window stays closed without a pulse.
- Per line, a capture sets the latch, the latch holds without an acknowledge, and an acknowledge clears it.

Other behaviours need the bench's scenarios against a cycle-level reference:
- The exact window length of 1500 cycles.
- The restart that extends the window.
- The release of captured lines after the window.
- Set-over-clear priority on a shared edge.
- The independence of lines under a partial acknowledge.

// File: rtl/wkg_pkg.sv
// Package: shared helpers for the wakeup guard.
// Assumes the product of clock frequency and window span fits in 64 bits.
package wkg_pkg;

    // Converts a span in nanoseconds to whole clock cycles, rounding up.
    function automatic longint unsigned span_to_cycles(
        input longint unsigned clk_hz,
        input longint unsigned span_ns
    );
        return (clk_hz * span_ns + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/wkg_keepout_timer.sv
// Module: down-counter that keeps the keep-out window open for HOLD cycles
// after the edge where start is sampled high. A start while the window
// is open reloads the full count.
// Assumes HOLD >= 1.
module wkg_keepout_timer #(
    parameter int unsigned HOLD = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] left_q;

    // Counts the remaining window cycles: load on start, then step to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - ONE;
        end
    end

    // Window flag: open while any cycles remain.
    always_comb begin
        active = (left_q != '0);
    end

    // R2: an idle counter never wraps into a new window by itself
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && left_q == '0) |=> (left_q == '0));

endmodule

// File: rtl/wkg_line_latch.sv
// Module: one wakeup line. It captures a request while the guard is
// holding requests back, keeps it until acknowledged, and gates the output.
// Assumes req and ack are synchronous to clk. Capture has priority over ack.
module wkg_line_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_back,
    input  logic req,
    input  logic ack,
    output logic fwd
);
    logic held_q;

    // Sticky capture: set by a blocked request, cleared by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= (hold_back & req) | (held_q & ~ack);
        end
    end

    // Forwarding: silent while holding back, otherwise live request or capture.
    always_comb begin
        fwd = hold_back ? 1'b0 : (req | held_q);
    end

    // R4: a request seen while holding back is captured
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_back && req) |=> held_q);

    // R5: a capture persists without an acknowledge
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !ack) |=> held_q);

    // R5: an acknowledge without a fresh capture clears the line
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(hold_back && req)) |=> !held_q);

endmodule

// File: rtl/wkg_wakeup_guard.sv
// Module: top of the low-power entry wakeup guard. An entry pulse opens a
// keep-out window of KEEPOUT_NS nanoseconds, counted in cycles of a
// CLK_HZ clock. Wakeup lines are held back and captured during the window,
// and during the entry pulse itself, then released.
// Assumes wakeup inputs are synchronous to clk.
module wkg_wakeup_guard #(
    parameter int unsigned CLK_HZ     = 250_000_000,
    parameter int unsigned KEEPOUT_NS = 6000,
    parameter int unsigned LINES      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_lp,
    input  logic [LINES-1:0] wake_in,
    input  logic [LINES-1:0] wake_ack,
    output logic [LINES-1:0] wake_out,
    output logic             window_active
);
    localparam int unsigned HOLD_CYCLES =
        32'(wkg_pkg::span_to_cycles(64'(CLK_HZ), 64'(KEEPOUT_NS)));

    logic             hold_back;
    logic [LINES-1:0] line_fwd;

    wkg_keepout_timer #(
        .HOLD (HOLD_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (enter_lp),
        .active (window_active)
    );

    // Hold-back condition: covers the open window and the entry cycle itself.
    always_comb begin
        hold_back = window_active | enter_lp;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        wkg_line_latch i_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_back (hold_back),
            .req       (wake_in[g]),
            .ack       (wake_ack[g]),
            .fwd       (line_fwd[g])
        );
    end

    // Output gate: nothing leaves the block while reset is asserted.
    always_comb begin
        wake_out = rst_n ? line_fwd : '0;
    end

    // R3: no request leaks out during the window or the entry cycle
    p_no_leak_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (window_active || enter_lp) |-> (wake_out == '0));

    // R2: an entry pulse opens the window on the next cycle
    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enter_lp |=> window_active);

    // R2: without a pulse a closed window stays closed
    p_stay_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enter_lp && !window_active) |=> !window_active);

    // R7: a pulse inside an open window keeps it open
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_lp && window_active) |=> window_active);

endmodule

// File: tb/test_wkg_wakeup_guard.sv
`timescale 1ns/1ps
// Bench: a driver task applies one cycle of stimulus and pushes the
// expected outputs, taken from a requirement-level model, into queues.
// A monitor pops and compares the queued values at each falling edge.
module test_wkg_wakeup_guard;
    localparam int KNS  = 6000;
    localparam int MHZ  = 250;
    localparam int HOLD = (KNS * MHZ + 999) / 1000;
    localparam int N    = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enter_lp = 1'b0;
    logic [N-1:0] wake_in = '0;
    logic [N-1:0] wake_ack = '0;
    logic [N-1:0] wake_out;
    logic         window_active;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    string        tag_q[$];
    logic [N-1:0] out_q[$];
    logic         act_q[$];

    int           m_left = 0;
    logic [N-1:0] m_held = '0;

    always #2 clk = ~clk;

    wkg_wakeup_guard #(
        .CLK_HZ(MHZ * 1_000_000), .KEEPOUT_NS(KNS), .LINES(N)
    ) i_wkg_wakeup_guard (
        .clk(clk), .rst_n(rst_n), .enter_lp(enter_lp), .wake_in(wake_in),
        .wake_ack(wake_ack), .wake_out(wake_out), .window_active(window_active)
    );

    // Applies one cycle of stimulus, queues the expected outputs and
    // advances the model to the next edge.
    task automatic step(input bit rn, input bit tr, input logic [N-1:0] w,
                        input logic [N-1:0] a, input string tag);
        bit blk;
        @(posedge clk); #1;
        rst_n = rn; enter_lp = tr; wake_in = w; wake_ack = a;
        blk = (m_left != 0) || tr;
        tag_q.push_back(tag);
        act_q.push_back(m_left != 0);
        out_q.push_back(!rn ? '0 : (blk ? '0 : (w | m_held)));
        if (!rn) begin
            m_left = 0; m_held = '0;
        end else begin
            m_held = (blk ? w : '0) | (m_held & ~a);
            m_left = tr ? HOLD : ((m_left != 0) ? m_left - 1 : 0);
        end
    endtask

    // Applies n quiet cycles with a steady wakeup pattern.
    task automatic idle(input int n, input logic [N-1:0] w, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, w, '0, tag);
    endtask

    // Pops one expectation per falling edge and compares it.
    always @(negedge clk) begin
        if (out_q.size() > 0) begin
            string t;
            logic [N-1:0] eo;
            logic ea;
            t = tag_q.pop_front(); eo = out_q.pop_front(); ea = act_q.pop_front();
            compared++;
            if (wake_out !== eo || window_active !== ea) begin
                mismatched++;
                $display("FAIL %s: wake_out=%b window_active=%b expected %b/%b at %0t",
                         t, wake_out, window_active, eo, ea, $time);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset clears everything, even with a trigger and requests present
        step(0, 0, '0, '0, "R1");
        step(0, 1, 4'hF, '0, "R1");
        step(0, 0, 4'hF, '0, "R1");
        step(0, 0, '0, '0, "R1");
        // R6: pass-through outside the window
        step(1, 0, 4'b0101, '0, "R6");
        step(1, 0, 4'b1010, '0, "R6");
        step(1, 0, 4'b0000, '0, "R6");
        // R9: request in the same cycle as the trigger is held back
        step(1, 1, 4'b0011, '0, "R9");
        idle(10, '0, "R3");
        // R4: a request inside the window is captured
        step(1, 0, 4'b0100, '0, "R4");
        // R2: window length, then release of captured lines 0..2
        idle(HOLD + 4, '0, "R2");
        // R8: acknowledging line 0 leaves lines 1 and 2 asserted
        step(1, 0, '0, 4'b0001, "R8");
        idle(3, '0, "R8");
        // R5: capture and ack on the same edge inside the window: set wins
        step(1, 1, '0, '0, "R5");
        step(1, 0, 4'b1000, 4'b1000, "R5");
        idle(HOLD + 2, '0, "R5");
        step(1, 0, '0, 4'b1110, "R5");
        idle(3, '0, "R5");
        // R7: a second trigger mid-window restarts the full count
        step(1, 1, '0, '0, "R7");
        idle(700, '0, "R7");
        step(1, 1, 4'b0001, '0, "R7");
        idle(HOLD + 3, '0, "R7");
        step(1, 0, '0, 4'b0001, "R7");
        // R6: after the window, live requests pass again
        step(1, 0, 4'b1001, '0, "R6");
        step(1, 0, '0, '0, "R6");
        // R1: reset in the middle of a window with captured lines
        step(1, 1, 4'b0110, '0, "R1");
        idle(5, '0, "R1");
        step(0, 0, '0, '0, "R1");
        step(1, 0, '0, '0, "R1");
        step(1, 0, '0, '0, "R1");
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule